// File: doc/BRIEF.md
# Register Stack Spill/Fill Engine

This block moves stacked general registers between a circular on-chip register file and a memory backing store, one 64-bit word per operation. Every register carries a one-bit deferred-exception tag. The engine keeps a store pointer and a load pointer into the backing store, plus a store index and a load index into the register file. A spill writes the register at the store index to the address in the store pointer. A fill reads the word just below the load pointer into the register just below the load index.

Tag bits are not stored beside each register in memory. Every backing-store address whose bits 8:3 are all ones holds a 64-bit tag-collection word instead. A spill gathers each register's tag into a collection register, at the bit given by the address's bits 8:3. A spill to a collection address writes out that collection register. A fill from a collection address loads a separate dispersal register. Each later register fill takes its tag from the dispersal register at the same bit position.

The engine also tracks how many registers are dirty, clean or in the current frame. Every other register counts as invalid. The core reaches the register file through a write port and a registered read port, and issues spill and fill requests as single-cycle pulses. Only one memory operation is outstanding at a time.

Top module: `regstack_spill_fill`

## Requirements
- R1: After a synchronous active-high reset, these values come from parameters: the store pointer, the load pointer, the store index, the load index and the dirty count. The clean count, frame count, collection word and dispersal word are zero, `busy` is low and no memory request is pending.
- R2: A spill to a store pointer whose bits 8:3 are not 63 does the following. It writes the register at the store index, with `mem_req_write`=1, to that address. It sets collection bit address[8:3] to the register's tag. On success the store pointer rises by 8, the store index rises by 1, the dirty count falls by 1 and the clean count rises by 1.
- R3: A spill to an address whose bits 8:3 equal 63 writes the collection word. On success the store pointer rises by 8, while the store index and all partition counts stay unchanged.
- R4: A fill to a non-collection address does the following. It reads address load pointer − 8 with `mem_req_write`=0 and writes the data to register (load index − 1). It sets that register's tag from dispersal bit address[8:3]. On success the load pointer falls by 8 and the load index becomes (load index − 1).
- R5: A fill whose address (load pointer − 8) has bits 8:3 equal to 63 loads the read word into the dispersal register. On success the load pointer falls by 8 and the load index stays unchanged.
- R6: A successful register fill adds one to the frame count if `frame_load_en` was 1 when the fill was accepted, and adds one to the clean count otherwise. The dirty, clean and frame counts together never exceed NREGS.
- R7: Indices wrap modulo NREGS. Spilling register NREGS−1 sets the store index to 0. A fill with load index 0 targets register NREGS−1.
- R8: A response with `mem_rsp_err`=1 leaves unchanged all pointers, indices, partition counts, the collection word, the dispersal word and the register file.
- R9: Only one operation is in flight at a time. Requests that arrive while `busy` is high are ignored. When a spill and a fill are requested in the same cycle, the spill is performed.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request's valid, address, direction and data stay stable.
- R11: A register spill request is refused while the dirty count is 0. A register fill request is refused while the invalid count (NREGS minus dirty, clean and frame) is 0. A refused request leaves `busy` low and nothing changes.
- R12: The external write port updates a register and its tag only while `busy` is low. The external read port returns data and tag one cycle after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spill_req | input | 1 | Request one spill (pulse) |
| fill_req | input | 1 | Request one fill (pulse) |
| frame_load_en | input | 1 | Route register fills to the current frame (1) or the clean partition (0) |
| rf_wr_en | input | 1 | External register write enable |
| rf_wr_idx | input | IDX_W | External write register index |
| rf_wr_data | input | XLEN | External write data |
| rf_wr_tag | input | 1 | External write tag bit |
| rf_rd_idx | input | IDX_W | External read register index |
| rf_rd_data | output | XLEN | External read data (registered) |
| rf_rd_tag | output | 1 | External read tag (registered) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write (spill), 0 = read (fill) |
| mem_req_addr | output | AW | Byte address of the 64-bit word |
| mem_req_wdata | output | XLEN | Write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_err | input | 1 | Memory response carries an error |
| mem_rsp_rdata | input | XLEN | Read data |
| busy | output | 1 | Operation in flight |
| store_ptr | output | AW | Store pointer |
| load_ptr | output | AW | Load pointer |
| store_idx | output | IDX_W | Store register index |
| load_idx | output | IDX_W | Load register index |
| dirty_cnt | output | CNT_W | Dirty partition size |
| clean_cnt | output | CNT_W | Clean partition size |
| frame_cnt | output | CNT_W | Current-frame registers loaded by fills |
| coll_word | output | XLEN | Tag-collection register |
| disp_word | output | XLEN | Tag-dispersal register |

## Verification
The assertions check on every cycle that pointers only step by 8 in their own direction, and that the store index moves only together with a one-step fall of the dirty count. They also check that an error response freezes all pointer state, that a stalled request holds still, that no request leaves an idle engine directly, and that the partition counts never exceed the register count. Only the bench scenarios can show the data path. This covers which register lands at which address, how tags are gathered into the collection word and written back out at the slot-63 address, and how the dispersal word later restores them. It also covers the index wrap, spill priority over a simultaneous fill, and a fill refused once the invalid partition is empty.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_REQ  = 2'd2,
    S_RSP  = 2'd3
  } rs_state_t;

  // Word slot within a 512-byte group: address bits 8:3
  function automatic logic [5:0] slot_of(input logic [63:0] a);
    return a[8:3];
  endfunction

  function automatic logic is_coll_slot(input logic [63:0] a);
    return (a[8:3] == 6'h3f);
  endfunction

endpackage

// File: rtl/rs_regfile.sv
module rs_regfile #(
  parameter int NREGS = 96,
  parameter int XLEN  = 64,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [XLEN-1:0]  wdata,
  input  logic             wtag,
  input  logic [IDX_W-1:0] raddr_a,
  output logic [XLEN-1:0]  rdata_a,
  output logic             rtag_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [XLEN-1:0]  rdata_b,
  output logic             rtag_b
);

  logic [XLEN-1:0] data_mem [NREGS];
  logic            tag_mem  [NREGS];

  always_ff @(posedge clk) begin
    if (we) begin
      data_mem[waddr] <= wdata;
      tag_mem[waddr]  <= wtag;
    end
  end

  always_ff @(posedge clk) begin
    rdata_a <= data_mem[raddr_a];
    rtag_a  <= tag_mem[raddr_a];
    rdata_b <= data_mem[raddr_b];
    rtag_b  <= tag_mem[raddr_b];
  end

endmodule

// File: rtl/rs_tagbank.sv
module rs_tagbank #(
  parameter int XLEN = 64,
  localparam int SLOT_W = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gather_en,
  input  logic [SLOT_W-1:0] gather_slot,
  input  logic              gather_bit,
  input  logic              disp_load,
  input  logic [XLEN-1:0]   disp_data,
  input  logic [SLOT_W-1:0] scatter_slot,
  output logic              scatter_bit,
  output logic [XLEN-1:0]   coll_q,
  output logic [XLEN-1:0]   disp_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      coll_q <= '0;
      disp_q <= '0;
    end else begin
      if (gather_en) coll_q[gather_slot] <= gather_bit;
      if (disp_load) disp_q <= disp_data;
    end
  end

  assign scatter_bit = disp_q[scatter_slot];

endmodule

// File: rtl/rs_partition.sv
module rs_partition #(
  parameter int NREGS      = 96,
  parameter int DIRTY_INIT = 8,
  localparam int CNT_W = $clog2(NREGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spill_done,
  input  logic             fill_done,
  input  logic             fill_to_frame,
  output logic [CNT_W-1:0] dirty_q,
  output logic [CNT_W-1:0] clean_q,
  output logic [CNT_W-1:0] frame_q,
  output logic [CNT_W-1:0] invalid_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dirty_q <= CNT_W'(DIRTY_INIT);
      clean_q <= '0;
      frame_q <= '0;
    end else begin
      if (spill_done) begin
        dirty_q <= dirty_q - 1'b1;
      end
      case ({spill_done, fill_done && !fill_to_frame})
        2'b10, 2'b01: clean_q <= clean_q + 1'b1;
        2'b11:        clean_q <= clean_q + 2'd2;
        default:      clean_q <= clean_q;
      endcase
      if (fill_done && fill_to_frame) begin
        frame_q <= frame_q + 1'b1;
      end
    end
  end

  assign invalid_n = CNT_W'(NREGS) - dirty_q - clean_q - frame_q;

endmodule

// File: rtl/regstack_spill_fill.sv
module regstack_spill_fill
  import rs_pkg::*;
#(
  parameter int          NREGS          = 96,
  parameter int          XLEN           = 64,
  parameter int          AW             = 64,
  parameter logic [63:0] STORE_PTR_INIT = 64'h0000_0000_0000_01E0,
  parameter logic [63:0] LOAD_PTR_INIT  = 64'h0000_0000_0000_2000,
  parameter int          SIDX_INIT      = 0,
  parameter int          LIDX_INIT      = 0,
  parameter int          DIRTY_INIT     = 8,
  localparam int IDX_W  = $clog2(NREGS),
  localparam int CNT_W  = $clog2(NREGS + 1),
  localparam int SLOT_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spill_req,
  input  logic             fill_req,
  input  logic             frame_load_en,
  input  logic             rf_wr_en,
  input  logic [IDX_W-1:0] rf_wr_idx,
  input  logic [XLEN-1:0]  rf_wr_data,
  input  logic             rf_wr_tag,
  input  logic [IDX_W-1:0] rf_rd_idx,
  output logic [XLEN-1:0]  rf_rd_data,
  output logic             rf_rd_tag,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [AW-1:0]    mem_req_addr,
  output logic [XLEN-1:0]  mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  input  logic [XLEN-1:0]  mem_rsp_rdata,
  output logic             busy,
  output logic [AW-1:0]    store_ptr,
  output logic [AW-1:0]    load_ptr,
  output logic [IDX_W-1:0] store_idx,
  output logic [IDX_W-1:0] load_idx,
  output logic [CNT_W-1:0] dirty_cnt,
  output logic [CNT_W-1:0] clean_cnt,
  output logic [CNT_W-1:0] frame_cnt,
  output logic [XLEN-1:0]  coll_word,
  output logic [XLEN-1:0]  disp_word
);

  localparam logic [AW-1:0]    WORD_BYTES = AW'(XLEN / 8);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(NREGS - 1);

  rs_state_t         state;
  logic              op_fill;
  logic              op_coll;
  logic              op_fle;
  logic              op_tag;
  logic [AW-1:0]     op_addr;
  logic [IDX_W-1:0]  op_reg;

  logic [XLEN-1:0]   eng_rd_data;
  logic              eng_rd_tag;
  logic              rf_we;
  logic [IDX_W-1:0]  rf_waddr;
  logic [XLEN-1:0]   rf_wdata;
  logic              rf_wtag;

  logic [CNT_W-1:0]  invalid_cnt;
  logic              scatter_bit;
  logic [AW-1:0]     fill_addr;
  logic              spill_is_coll;
  logic              fill_is_coll;
  logic              spill_ok;
  logic              fill_ok;
  logic              rsp_ok;
  logic              spill_reg_done;
  logic              fill_reg_done;
  logic              disp_load;
  logic [SLOT_W-1:0] op_slot;
  logic [IDX_W-1:0]  store_idx_nxt;
  logic [IDX_W-1:0]  load_idx_prev;

  // ---------------- request qualification ----------------
  assign fill_addr     = load_ptr - WORD_BYTES;
  assign spill_is_coll = is_coll_slot(64'(store_ptr));
  assign fill_is_coll  = is_coll_slot(64'(fill_addr));
  assign spill_ok      = spill_is_coll || (dirty_cnt != '0);
  assign fill_ok       = fill_is_coll || (invalid_cnt != '0);
  assign store_idx_nxt = (store_idx == IDX_LAST) ? '0 : store_idx + 1'b1;
  assign load_idx_prev = (load_idx == '0) ? IDX_LAST : load_idx - 1'b1;
  assign op_slot       = SLOT_W'(slot_of(64'(op_addr)));

  // ---------------- completion decode ----------------
  assign rsp_ok         = (state == S_RSP) && mem_rsp_valid && !mem_rsp_err;
  assign spill_reg_done = rsp_ok && !op_fill && !op_coll;
  assign fill_reg_done  = rsp_ok &&  op_fill && !op_coll;
  assign disp_load      = rsp_ok &&  op_fill &&  op_coll;
  assign busy           = (state != S_IDLE);

  // ---------------- register file write mux ----------------
  always_comb begin
    if (fill_reg_done) begin
      rf_we    = 1'b1;
      rf_waddr = op_reg;
      rf_wdata = mem_rsp_rdata;
      rf_wtag  = scatter_bit;
    end else begin
      rf_we    = rf_wr_en && (state == S_IDLE);
      rf_waddr = rf_wr_idx;
      rf_wdata = rf_wr_data;
      rf_wtag  = rf_wr_tag;
    end
  end

  rs_regfile #(
    .NREGS (NREGS),
    .XLEN  (XLEN)
  ) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .wtag    (rf_wtag),
    .raddr_a (store_idx),
    .rdata_a (eng_rd_data),
    .rtag_a  (eng_rd_tag),
    .raddr_b (rf_rd_idx),
    .rdata_b (rf_rd_data),
    .rtag_b  (rf_rd_tag)
  );

  rs_tagbank #(
    .XLEN (XLEN)
  ) u_tags (
    .clk          (clk),
    .rst          (rst),
    .gather_en    (spill_reg_done),
    .gather_slot  (op_slot),
    .gather_bit   (op_tag),
    .disp_load    (disp_load),
    .disp_data    (mem_rsp_rdata),
    .scatter_slot (op_slot),
    .scatter_bit  (scatter_bit),
    .coll_q       (coll_word),
    .disp_q       (disp_word)
  );

  rs_partition #(
    .NREGS      (NREGS),
    .DIRTY_INIT (DIRTY_INIT)
  ) u_part (
    .clk           (clk),
    .rst           (rst),
    .spill_done    (spill_reg_done),
    .fill_done     (fill_reg_done),
    .fill_to_frame (op_fle),
    .dirty_q       (dirty_cnt),
    .clean_q       (clean_cnt),
    .frame_q       (frame_cnt),
    .invalid_n     (invalid_cnt)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      op_fill       <= 1'b0;
      op_coll       <= 1'b0;
      op_fle        <= 1'b0;
      op_tag        <= 1'b0;
      op_addr       <= '0;
      op_reg        <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      store_ptr     <= AW'(STORE_PTR_INIT);
      load_ptr      <= AW'(LOAD_PTR_INIT);
      store_idx     <= IDX_W'(SIDX_INIT);
      load_idx      <= IDX_W'(LIDX_INIT);
    end else begin
      case (state)
        S_IDLE: begin
          if (spill_req && spill_ok) begin
            op_fill <= 1'b0;
            op_coll <= spill_is_coll;
            op_fle  <= 1'b0;
            op_addr <= store_ptr;
            op_reg  <= store_idx;
            state   <= S_RD;
          end else if (fill_req && fill_ok) begin
            op_fill <= 1'b1;
            op_coll <= fill_is_coll;
            op_fle  <= frame_load_en;
            op_addr <= fill_addr;
            op_reg  <= load_idx_prev;
            state   <= S_RD;
          end
        end
        S_RD: begin
          op_tag        <= eng_rd_tag;
          mem_req_valid <= 1'b1;
          mem_req_write <= !op_fill;
          mem_req_addr  <= op_addr;
          mem_req_wdata <= op_fill ? '0 : (op_coll ? coll_word : eng_rd_data);
          state         <= S_REQ;
        end
        S_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= S_RSP;
          end
        end
        S_RSP: begin
          if (mem_rsp_valid) begin
            state <= S_IDLE;
            if (!mem_rsp_err) begin
              if (op_fill) begin
                load_ptr <= load_ptr - WORD_BYTES;
                if (!op_coll) load_idx <= op_reg;
              end else begin
                store_ptr <= store_ptr + WORD_BYTES;
                if (!op_coll) store_idx <= store_idx_nxt;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rs_sva.sv
module rs_sva #(
  parameter int NREGS = 96,
  parameter int XLEN  = 64,
  parameter int AW    = 64,
  localparam int IDX_W = $clog2(NREGS),
  localparam int CNT_W = $clog2(NREGS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [AW-1:0]    mem_req_addr,
  input logic [XLEN-1:0]  mem_req_wdata,
  input logic             mem_rsp_valid,
  input logic             mem_rsp_err,
  input logic [AW-1:0]    store_ptr,
  input logic [AW-1:0]    load_ptr,
  input logic [IDX_W-1:0] store_idx,
  input logic [IDX_W-1:0] load_idx,
  input logic [CNT_W-1:0] dirty_cnt,
  input logic [CNT_W-1:0] clean_cnt,
  input logic [CNT_W-1:0] frame_cnt
);

  localparam logic [AW-1:0] STEP = AW'(XLEN / 8);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  // R2
  store_step_chk: assert property (@(posedge clk) disable iff (rst)
    (store_ptr != $past(store_ptr)) |-> (store_ptr == $past(store_ptr) + STEP));

  // R4
  load_step_chk: assert property (@(posedge clk) disable iff (rst)
    (load_ptr != $past(load_ptr)) |-> (load_ptr == $past(load_ptr) - STEP));

  // R3
  idx_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (store_idx != $past(store_idx)) |-> (dirty_cnt == $past(dirty_cnt) - 1'b1));

  // R8
  err_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && mem_rsp_err) |=>
      ($stable(store_ptr) && $stable(load_ptr) && $stable(store_idx) && $stable(load_idx)
       && $stable(dirty_cnt) && $stable(clean_cnt) && $stable(frame_cnt)));

  // R9
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !mem_req_valid);

  // R11
  empty_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (dirty_cnt == '0) |=> $stable(store_idx));

  // R6
  part_sum_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, dirty_cnt} + {1'b0, clean_cnt} + {1'b0, frame_cnt}) <= (CNT_W + 1)'(NREGS));

endmodule

bind regstack_spill_fill rs_sva #(
  .NREGS (NREGS),
  .XLEN  (XLEN),
  .AW    (AW)
) u_rs_sva (
  .clk           (clk),
  .rst           (rst),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_err   (mem_rsp_err),
  .store_ptr     (store_ptr),
  .load_ptr      (load_ptr),
  .store_idx     (store_idx),
  .load_idx      (load_idx),
  .dirty_cnt     (dirty_cnt),
  .clean_cnt     (clean_cnt),
  .frame_cnt     (frame_cnt)
);

// File: tb/tb_regstack_spill_fill.sv
module tb_regstack_spill_fill;

  localparam int NREGS = 96;
  localparam int XLEN  = 64;
  localparam int AW    = 64;
  localparam int IDX_W = $clog2(NREGS);
  localparam int CNT_W = $clog2(NREGS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic spill_req = 0, fill_req = 0, frame_load_en = 0;
  logic rf_wr_en = 0, rf_wr_tag = 0;
  logic [IDX_W-1:0] rf_wr_idx = '0, rf_rd_idx = '0;
  logic [XLEN-1:0]  rf_wr_data = '0;
  logic [XLEN-1:0]  rf_rd_data;
  logic             rf_rd_tag;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1;
  logic [AW-1:0] mem_req_addr;
  logic [XLEN-1:0] mem_req_wdata;
  logic mem_rsp_valid = 0, mem_rsp_err = 0;
  logic [XLEN-1:0] mem_rsp_rdata = '0;
  logic busy;
  logic [AW-1:0] store_ptr, load_ptr;
  logic [IDX_W-1:0] store_idx, load_idx;
  logic [CNT_W-1:0] dirty_cnt, clean_cnt, frame_cnt;
  logic [XLEN-1:0] coll_word, disp_word;

  regstack_spill_fill #(
    .NREGS(NREGS), .XLEN(XLEN), .AW(AW),
    .STORE_PTR_INIT(64'h1E0), .LOAD_PTR_INIT(64'h2000),
    .SIDX_INIT(94), .LIDX_INIT(0), .DIRTY_INIT(90)
  ) dut (.*);

  int total = 0, bad = 0;
  logic stall = 0, err_mode = 0;
  logic [XLEN-1:0] bmem [1024];
  logic pend = 0;
  logic [XLEN-1:0] pend_rdata = '0;
  logic last_write = 0;
  logic [AW-1:0] last_addr = '0;
  logic [XLEN-1:0] last_wdata = '0;

  function automatic logic [XLEN-1:0] fpat(input logic [AW-1:0] a);
    return {32'hF11D_0000, a[31:0]};
  endfunction

  task automatic chk(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // memory responder
  initial forever begin
    @(negedge clk);
    mem_rsp_valid = 0;
    if (pend) begin
      mem_rsp_valid = 1;
      mem_rsp_err   = err_mode;
      mem_rsp_rdata = pend_rdata;
      pend = 0;
    end
    mem_req_ready = !stall;
    if (mem_req_valid && mem_req_ready) begin
      pend       = 1;
      last_write = mem_req_write;
      last_addr  = mem_req_addr;
      last_wdata = mem_req_wdata;
      if (mem_req_write && !err_mode) bmem[mem_req_addr[12:3]] = mem_req_wdata;
      pend_rdata = bmem[mem_req_addr[12:3]];
    end
  end

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic pulse(input logic s, input logic f);
    @(negedge clk);
    spill_req = s; fill_req = f;
    @(negedge clk);
    spill_req = 0; fill_req = 0;
    wait_idle();
  endtask

  task automatic ext_write(input int idx, input logic [XLEN-1:0] d, input logic t);
    @(negedge clk);
    rf_wr_en = 1; rf_wr_idx = IDX_W'(idx); rf_wr_data = d; rf_wr_tag = t;
    @(negedge clk);
    rf_wr_en = 0;
  endtask

  task automatic ext_read(input int idx, output logic [XLEN-1:0] d, output logic t);
    rf_rd_idx = IDX_W'(idx);
    @(negedge clk);
    d = rf_rd_data; t = rf_rd_tag;
  endtask

  task automatic t_reset();
    chk("R1 store_ptr", store_ptr, 64'h1E0);
    chk("R1 load_ptr", load_ptr, 64'h2000);
    chk("R1 store_idx", 64'(store_idx), 64'd94);
    chk("R1 load_idx", 64'(load_idx), 64'd0);
    chk("R1 dirty", 64'(dirty_cnt), 64'd90);
    chk("R1 clean/frame", 64'({clean_cnt, frame_cnt}), 64'd0);
    chk("R1 busy/valid", 64'({busy, mem_req_valid}), 64'd0);
    chk("R1 coll/disp", coll_word | disp_word, 64'd0);
  endtask

  task automatic t_preload();
    logic [XLEN-1:0] d; logic t;
    ext_write(94, 64'h1111_0000_0000_0094, 1);
    ext_write(95, 64'h1111_0000_0000_0095, 0);
    ext_write(0,  64'h1111_0000_0000_0000, 1);
    ext_write(1,  64'h1111_0000_0000_0001, 1);
    ext_write(2,  64'h1111_0000_0000_0002, 0);
    ext_write(10, 64'hAAAA_AAAA_AAAA_AAAA, 0);
    ext_read(95, d, t);
    chk("R12 read data", d, 64'h1111_0000_0000_0095);
    chk("R12 read tag", 64'(t), 64'd0);
  endtask

  task automatic t_spill_regs();
    pulse(1, 0);
    chk("R2 spill addr", last_addr, 64'h1E0);
    chk("R2 spill data", bmem[10'h3C], 64'h1111_0000_0000_0094);
    chk("R2 spill write", 64'(last_write), 64'd1);
    chk("R2 store_ptr", store_ptr, 64'h1E8);
    chk("R2 store_idx", 64'(store_idx), 64'd95);
    chk("R2 dirty/clean", 64'({dirty_cnt, clean_cnt}), 64'({7'd89, 7'd1}));
    chk("R2 coll bit60", coll_word, 64'h1000_0000_0000_0000);
    pulse(1, 0);
    chk("R7 store_idx wrap", 64'(store_idx), 64'd0);
    chk("R2 coll bit61 clear", coll_word, 64'h1000_0000_0000_0000);
  endtask

  task automatic t_spill_err();
    err_mode = 1;
    pulse(1, 0);
    err_mode = 0;
    chk("R8 store_ptr", store_ptr, 64'h1F0);
    chk("R8 store_idx", 64'(store_idx), 64'd0);
    chk("R8 dirty/clean", 64'({dirty_cnt, clean_cnt}), 64'({7'd88, 7'd2}));
    chk("R8 coll", coll_word, 64'h1000_0000_0000_0000);
    pulse(1, 0);
    chk("R2 retry coll", coll_word, 64'h5000_0000_0000_0000);
    chk("R2 retry idx", 64'(store_idx), 64'd1);
  endtask

  task automatic t_spill_coll();
    pulse(1, 0);
    chk("R3 coll addr", last_addr, 64'h1F8);
    chk("R3 coll data", bmem[10'h3F], 64'h5000_0000_0000_0000);
    chk("R3 store_ptr", store_ptr, 64'h200);
    chk("R3 idx held", 64'(store_idx), 64'd1);
    chk("R3 counts held", 64'({dirty_cnt, clean_cnt}), 64'({7'd87, 7'd3}));
  endtask

  task automatic t_stall();
    logic [AW-1:0] a0;
    stall = 1;
    @(negedge clk); spill_req = 1;
    @(negedge clk); spill_req = 0;
    @(negedge clk);
    a0 = mem_req_addr;
    fill_req = 1;
    @(negedge clk); fill_req = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R10 valid held", 64'(mem_req_valid), 64'd1);
      chk("R10 addr held", mem_req_addr, a0);
      @(negedge clk);
    end
    stall = 0;
    wait_idle();
    chk("R10 addr", a0, 64'h200);
    chk("R10 data", bmem[10'h40], 64'h1111_0000_0000_0001);
    chk("R2 coll bit0", coll_word, 64'h5000_0000_0000_0001);
    chk("R9 busy fill ignored", load_ptr, 64'h2000);
  endtask

  task automatic t_both();
    pulse(1, 1);
    chk("R9 spill wins write", 64'(last_write), 64'd1);
    chk("R9 store_ptr", store_ptr, 64'h210);
    chk("R9 load_ptr", load_ptr, 64'h2000);
    chk("R9 store_idx", 64'(store_idx), 64'd3);
  endtask

  task automatic t_fills();
    logic [XLEN-1:0] d; logic t;
    pulse(0, 1);
    chk("R5 fill read", 64'(last_write), 64'd0);
    chk("R5 disp", disp_word, 64'h4C00_0000_0000_0000);
    chk("R5 load_ptr", load_ptr, 64'h1FF8);
    chk("R5 load_idx held", 64'(load_idx), 64'd0);
    frame_load_en = 1;
    pulse(0, 1);
    frame_load_en = 0;
    chk("R4 fill addr", last_addr, 64'h1FF0);
    chk("R7 load_idx wrap", 64'(load_idx), 64'd95);
    chk("R6 frame count", 64'(frame_cnt), 64'd1);
    ext_read(95, d, t);
    chk("R4 reg data", d, fpat(64'h1FF0));
    chk("R4 reg tag", 64'(t), 64'd1);
    pulse(0, 1);
    chk("R6 clean count", 64'(clean_cnt), 64'd6);
    chk("R4 load_ptr", load_ptr, 64'h1FE8);
    ext_read(94, d, t);
    chk("R4 reg94 data", d, fpat(64'h1FE8));
    chk("R4 reg94 tag", 64'(t), 64'd0);
  endtask

  task automatic t_busy_write();
    logic [XLEN-1:0] d; logic t;
    stall = 1;
    @(negedge clk); fill_req = 1;
    @(negedge clk); fill_req = 0;
    rf_wr_en = 1; rf_wr_idx = IDX_W'(10); rf_wr_data = 64'h5555; rf_wr_tag = 1;
    @(negedge clk); rf_wr_en = 0;
    stall = 0;
    wait_idle();
    ext_read(10, d, t);
    chk("R12 busy write ignored", d, 64'hAAAA_AAAA_AAAA_AAAA);
    chk("R12 busy tag ignored", 64'(t), 64'd0);
    chk("R6 clean after fill", 64'(clean_cnt), 64'd7);
  endtask

  task automatic t_refuse();
    logic [XLEN-1:0] d; logic t;
    frame_load_en = 1;
    for (int i = 0; i < 3; i++) pulse(0, 1);
    frame_load_en = 0;
    chk("R6 frame count 4", 64'(frame_cnt), 64'd4);
    chk("R4 load_ptr", load_ptr, 64'h1FC8);
    ext_read(92, d, t);
    chk("R4 reg92 tag", 64'(t), 64'd1);
    @(negedge clk); fill_req = 1;
    @(negedge clk); fill_req = 0;
    chk("R11 refused busy", 64'(busy), 64'd0);
    repeat (3) @(negedge clk);
    chk("R11 load_ptr held", load_ptr, 64'h1FC8);
    chk("R11 load_idx held", 64'(load_idx), 64'd90);
  endtask

  initial begin
    bmem[10'h3FF] = 64'h4C00_0000_0000_0000;
    for (int a = 32'h1F00; a < 32'h1FF8; a += 8) bmem[a[12:3]] = fpat(64'(a));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_preload();
    t_spill_regs();
    t_spill_err();
    t_spill_coll();
    t_stall();
    t_both();
    t_fills();
    t_busy_write();
    t_refuse();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule